// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a write-only two-wire serial slave that lets a host controller load a bank of eight 8-bit control registers. It runs on the system clock and oversamples the serial clock and data lines through two-flop synchronizers. It recognises START and STOP framing, compares the first byte against a fixed 7-bit device address, and acknowledges each byte it accepts by pulling the data line low during the ninth clock. The data line is never driven high.

After the address comes one subaddress byte. Its low three bits pick a register, and bit 4 chooses whether the pointer advances after each data byte. Any number of data bytes then follow until STOP. The registers drive a flat parallel output that the rest of the chip reads. Register 0 is reserved: writes to it are acknowledged and then dropped. A START is accepted only after a STOP, so a START inside an open transfer abandons that transfer.

Top module: `i2c_cfg_slave`

## Requirements
- R1: After reset every register output reads zero, the pointer is at index 0 and `sda_oe` is low.
- R2: A first byte of 0x8A (address 1000101, sent MSB first, then a write bit of 0) is acknowledged: `sda_oe` holds the data line low through the whole ninth SCL high period.
- R3: `sda_oe` changes only while the synchronized SCL is low, and the block only pulls the line low.
- R4: In the subaddress byte, bits 2:0 are the register index and bit 4 enables auto-increment. Bits 7:5 and bit 3 have no effect. The byte is acknowledged.
- R5: Each data byte is acknowledged and written to `regs_o[8*idx+7 : 8*idx]`. The register outputs change only when a data byte completes.
- R6: With auto-increment on, each data byte moves the pointer to the next index, and the pointer wraps from 7 to 0.
- R7: With auto-increment off, every data byte in the transfer overwrites the same register.
- R8: A first byte that does not match the address, or that carries a read bit of 1, gets no acknowledge. Every later byte is then ignored and left unacknowledged until STOP.
- R9: A data byte aimed at index 0 is acknowledged but not stored. Bits 7:0 of `regs_o` always read zero.
- R10: A START that arrives while a transfer is open, with no STOP before it, abandons the transfer. Bytes after it are neither acknowledged nor stored until STOP.
- R11: STOP closes any transfer and leaves SDA released. The next START begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | When high, the pad pulls the data line low (open drain) |
| regs_o | output | NUM_REGS*DATA_W | Register bank, register k in bits 8k+7 down to 8k |

## Verification
The assertions assume a well-behaved host. It holds each SCL level for more system clocks than the synchronizer delay. It moves SDA only while SCL is low, except when it signals START or STOP. It never signals START or STOP inside an acknowledge slot. The bench drives the bus with quarter periods of eight system clocks and changes its lines on the falling system-clock edge. It issues START and STOP only with SCL settled high, after an acknowledge slot has ended, so the stimulus stays within these assumptions while still covering the address mismatch, the read bit and a restart without STOP.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_SUB,
    PH_DATA,
    PH_SKIP
  } phase_t;

  localparam int AINC_BIT = 4;

  // First byte of a write to this device: 7-bit address then a 0 direction bit.
  function automatic logic addr_match(input logic [7:0] b, input logic [6:0] dev);
    return (b[7:1] == dev) && (b[0] == 1'b0);
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_chain;
  logic [SYNC_STAGES-1:0] sda_chain;
  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_chain <= '1;
      sda_chain <= '1;
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
    end else begin
      scl_chain <= {scl_chain[SYNC_STAGES-2:0], scl_i};
      sda_chain <= {sda_chain[SYNC_STAGES-2:0], sda_i};
      scl_q     <= scl_chain[SYNC_STAGES-1];
      sda_q     <= sda_chain[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_chain[SYNC_STAGES-1];
  assign sda_s     = sda_chain[SYNC_STAGES-1];
  assign scl_rise  =  scl_s && !scl_q;
  assign scl_fall  = !scl_s &&  scl_q;
  assign start_det =  scl_s && scl_q &&  sda_q && !sda_s;
  assign stop_det  =  scl_s && scl_q && !sda_q &&  sda_s;

endmodule

// File: rtl/i2c_byte_rx.sv
module i2c_byte_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  input  logic              frame_clr,
  input  logic              ack_req,
  output logic              byte_done,
  output logic [DATA_W-1:0] byte_val,
  output logic              sda_oe
);
  localparam int BIT_W = $clog2(DATA_W);

  logic [BIT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] shreg;
  logic              full;     // eight bits in, waiting for SCL low
  logic              in_ack;   // ninth clock in progress
  logic              ack_hold;
  logic              bit_slot;

  assign bit_slot  = scl_rise && !full && !in_ack;
  assign byte_done = bit_slot && (bit_cnt == BIT_W'(DATA_W-1));
  assign byte_val  = {shreg[DATA_W-2:0], sda_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      shreg    <= '0;
      full     <= 1'b0;
      in_ack   <= 1'b0;
      ack_hold <= 1'b0;
      sda_oe   <= 1'b0;
    end else if (frame_clr) begin
      bit_cnt  <= '0;
      full     <= 1'b0;
      in_ack   <= 1'b0;
      ack_hold <= 1'b0;
      sda_oe   <= 1'b0;
    end else begin
      if (bit_slot) begin
        shreg <= byte_val;
        if (byte_done) begin
          full     <= 1'b1;
          bit_cnt  <= '0;
          ack_hold <= ack_req;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
      if (scl_fall && full) begin
        full   <= 1'b0;
        in_ack <= 1'b1;
        sda_oe <= ack_hold;
      end else if (scl_fall && in_ack) begin
        in_ack <= 1'b0;
        sda_oe <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
  import i2c_cfg_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 8,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sub_load,
  input  logic [IDX_W-1:0]           sub_idx,
  input  logic                       sub_ainc,
  input  logic                       wr_en,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [IDX_W-1:0]           ptr,
  output logic                       ainc,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);

  // Pointer after a data byte; the bank size is a power of two, so it wraps.
  function automatic logic [IDX_W-1:0] next_idx(input logic [IDX_W-1:0] idx, input logic step);
    return step ? IDX_W'(idx + 1'b1) : idx;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      ainc <= 1'b0;
    end else if (sub_load) begin
      ptr  <= sub_idx;
      ainc <= sub_ainc;
    end else if (wr_en) begin
      ptr <= next_idx(ptr, ainc);
    end
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i == 0) begin : g_reserved
      assign regs_o[DATA_W-1:0] = '0;
    end else begin : g_store
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          q <= '0;
        else if (wr_en && ptr == IDX_W'(i))  q <= wr_data;
      end
      assign regs_o[i*DATA_W +: DATA_W] = q;
    end
  end

endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave
  import i2c_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b1000101,
  parameter int         NUM_REGS    = 8,
  parameter int         DATA_W      = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       sda_oe,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  localparam int IDX_W = $clog2(NUM_REGS);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic frame_clr, ack_req, byte_done;
  logic [DATA_W-1:0] byte_val;
  logic sub_load, wr_en;
  logic [IDX_W-1:0] ptr;
  logic ainc;
  phase_t phase;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign frame_clr = start_det || stop_det;

  always_comb begin
    case (phase)
      PH_ADDR:         ack_req = addr_match(byte_val[7:0], DEV_ADDR);
      PH_SUB, PH_DATA: ack_req = 1'b1;
      default:         ack_req = 1'b0;
    endcase
  end

  i2c_byte_rx #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_s(sda_s), .frame_clr(frame_clr), .ack_req(ack_req),
    .byte_done(byte_done), .byte_val(byte_val), .sda_oe(sda_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
    end else if (stop_det) begin
      phase <= PH_IDLE;
    end else if (start_det) begin
      phase <= (phase == PH_IDLE) ? PH_ADDR : PH_SKIP;
    end else if (byte_done) begin
      case (phase)
        PH_ADDR: phase <= ack_req ? PH_SUB : PH_SKIP;
        PH_SUB:  phase <= PH_DATA;
        default: phase <= phase;
      endcase
    end
  end

  assign sub_load = byte_done && (phase == PH_SUB);
  assign wr_en    = byte_done && (phase == PH_DATA);

  i2c_reg_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .sub_load(sub_load),
    .sub_idx(byte_val[IDX_W-1:0]), .sub_ainc(byte_val[AINC_BIT]),
    .wr_en(wr_en), .wr_data(byte_val), .ptr(ptr), .ainc(ainc), .regs_o(regs_o)
  );

endmodule

// File: rtl/i2c_cfg_checker.sv
module i2c_cfg_checker
  import i2c_cfg_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 8,
  parameter int IDX_W    = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       scl_s,
  input logic                       sda_oe,
  input logic                       start_det,
  input logic                       wr_en,
  input logic                       ainc,
  input logic [IDX_W-1:0]           ptr,
  input phase_t                     phase,
  input logic [NUM_REGS*DATA_W-1:0] regs_o
);

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) || $fell(sda_oe)) |-> !scl_s); // R3

  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_o)); // R5

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ainc) |=> (ptr == IDX_W'($past(ptr) + 1'b1))); // R6

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ainc) |=> $stable(ptr)); // R7

  AST_SKIP_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SKIP) |=> $stable(regs_o)); // R8

  AST_IDX0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    regs_o[DATA_W-1:0] == '0); // R9

  AST_BAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && phase != PH_IDLE) |=> (phase == PH_SKIP)); // R10

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> !sda_oe); // R11

endmodule

bind i2c_cfg_slave i2c_cfg_checker #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .start_det(start_det), .wr_en(wr_en), .ainc(ainc), .ptr(ptr),
  .phase(phase), .regs_o(regs_o)
);

// File: tb/i2c_cfg_slave_test.sv
module i2c_cfg_slave_test;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [63:0] regs_o;
  wire  sda_line = sda_m & ~sda_oe;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit settled = 1'b1;

  // behavioural model of the slave
  logic [63:0] exp_flat = '0;
  int m_state = 0;   // 0 idle, 1 address, 2 subaddress, 3 data, 4 ignoring
  int m_ptr = 0;
  bit m_ainc = 1'b0;

  always #5 clk = ~clk;

  i2c_cfg_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .regs_o(regs_o)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wait_q(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  // registers compared with the model on every clock outside the update window
  always @(negedge clk) begin
    if (rst_n && settled && !done) chk("R5 regs", regs_o, exp_flat);
  end

  // R3: the slave's drive may only move while the host holds SCL low
  int r3_bad = 0;
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && (sda_oe !== oe_prev) && scl_m) r3_bad++;
    oe_prev = sda_oe;
  end

  task automatic do_start();
    sda_m = 1'b1; wait_q(1);
    scl_m = 1'b1; wait_q(1);
    sda_m = 1'b0; wait_q(1);
    scl_m = 1'b0; wait_q(1);
    m_state = (m_state == 0) ? 1 : 4;
  endtask

  task automatic do_stop();
    sda_m = 1'b0; wait_q(1);
    scl_m = 1'b1; wait_q(1);
    sda_m = 1'b1; wait_q(1);
    m_state = 0;
    chk("R11 released after stop", sda_oe, 1'b0);
  endtask

  task automatic model_byte(input logic [7:0] b, output bit ack);
    case (m_state)
      1: begin ack = (b == 8'h8A); m_state = ack ? 2 : 4; end
      2: begin m_ptr = b[2:0]; m_ainc = b[4]; ack = 1'b1; m_state = 3; end
      3: begin
           if (m_ptr != 0) exp_flat[m_ptr*8 +: 8] = b;
           if (m_ainc) m_ptr = (m_ptr + 1) % 8;
           ack = 1'b1;
         end
      default: ack = 1'b0;
    endcase
  endtask

  task automatic send_byte(input logic [7:0] b, input string tag);
    bit ack;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_q(1);
      if (i == 0) settled = 1'b0;
      scl_m = 1'b1; wait_q(2);
      scl_m = 1'b0; wait_q(1);
    end
    model_byte(b, ack);
    settled = 1'b1;
    sda_m = 1'b1; wait_q(1);
    scl_m = 1'b1; wait_q(1);
    chk(tag, sda_line, ack ? 1'b0 : 1'b1);
    wait_q(1);
    chk(tag, sda_line, ack ? 1'b0 : 1'b1);
    scl_m = 1'b0; wait_q(1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 regs at reset", regs_o, 64'h0);
    chk("R1 sda_oe at reset", sda_oe, 1'b0);

    // R2 R5 R6: auto-increment burst from index 1
    do_start();
    send_byte(8'h8A, "R2 address ack");
    send_byte(8'h11, "R4 subaddress ack");
    send_byte(8'h21, "R5 data ack");
    send_byte(8'h32, "R5 data ack");
    send_byte(8'h43, "R5 data ack");
    send_byte(8'h54, "R5 data ack");
    send_byte(8'h65, "R5 data ack");
    do_stop();
    chk("R6 burst landed", regs_o, 64'h0000_0065_5443_3221 << 8);

    // R4 R6 R9: ignored high bits, wrap from 7 through reserved 0 to 1
    do_start();
    send_byte(8'h8A, "R2 address ack");
    send_byte(8'hF6, "R4 subaddress with junk bits");
    send_byte(8'hA6, "R6 data ack");
    send_byte(8'hA7, "R6 data ack");
    send_byte(8'hA0, "R9 index 0 acked");
    send_byte(8'hA1, "R6 wrapped data ack");
    do_stop();
    chk("R9 index 0 reads zero", regs_o[7:0], 8'h00);
    chk("R6 wrap result", regs_o[63:48], 16'hA7A6);
    chk("R6 wrap result", regs_o[15:8], 8'hA1);

    // R7: no auto-increment, bit 3 set, index 3 overwritten
    do_start();
    send_byte(8'h8A, "R2 address ack");
    send_byte(8'hEB, "R4 subaddress bit3 ignored");
    send_byte(8'h13, "R7 data ack");
    send_byte(8'h23, "R7 data ack");
    send_byte(8'h33, "R7 data ack");
    do_stop();
    chk("R7 last byte kept", regs_o[31:24], 8'h33);
    chk("R7 neighbour intact", regs_o[39:32], 8'h54);

    // R8: wrong address, then read bit
    do_start();
    send_byte(8'h90, "R8 wrong address nack");
    send_byte(8'h12, "R8 ignored byte");
    send_byte(8'hEE, "R8 ignored byte");
    do_stop();
    do_start();
    send_byte(8'h8B, "R8 read bit nack");
    send_byte(8'h13, "R8 ignored byte");
    do_stop();

    // R10: START without STOP abandons the transfer
    do_start();
    send_byte(8'h8A, "R2 address ack");
    send_byte(8'h12, "R4 subaddress ack");
    send_byte(8'h5A, "R5 data ack");
    do_start();
    send_byte(8'h8A, "R10 restart address nack");
    send_byte(8'h13, "R10 ignored byte");
    send_byte(8'h77, "R10 ignored byte");
    do_stop();
    chk("R10 only first byte stored", regs_o[31:16], 16'h335A);

    // R11: a fresh transfer after STOP works
    do_start();
    send_byte(8'h8A, "R11 address ack after stop");
    send_byte(8'h07, "R4 subaddress ack");
    send_byte(8'hC3, "R5 data ack");
    send_byte(8'hC4, "R7 data ack");
    do_stop();
    chk("R11 write after stop", regs_o[63:56], 8'hC4);

    // R9: direct write to index 0
    do_start();
    send_byte(8'h8A, "R2 address ack");
    send_byte(8'h00, "R4 subaddress ack");
    send_byte(8'hFF, "R9 index 0 acked");
    do_stop();
    chk("R9 index 0 not stored", regs_o[7:0], 8'h00);

    chk("R3 drive moved only with SCL low", r3_bad, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule